// File: doc/BRIEF.md
# Power-on reset timeout sequencer

This block keeps a small processor core in reset after power is applied until its clock can be trusted. A power-up wait is counted first on a slow internal RC clock. In crystal oscillator modes, an oscillator settling wait of a fixed number of main-oscillator cycles follows. In the PLL crystal mode, a PLL lock wait counted on the RC clock comes last. Which waits run depends on the oscillator mode, on a power-up wait enable bit, and on what started the sequence: a power-on pulse or a wake from a low-power mode.

The external active-low master clear only gates the final release. The waits always run from the power-on pulse. If master clear is held low past the end of every wait, the core starts within a few oscillator cycles of master clear going high. A new power-on pulse at any point throws away the sequence in progress and starts it again from the beginning.

A stage output shows where the sequence stands, so the order of the waits can be observed.

Top module: `por_seq_top`

## Requirements
- R1: While `por` is high, `stage_o` reads 0 (idle) and `core_hold` is 1.
- R2: With `cfg_pwrt_n` = 0, the first stage after `por` falls is the power-up wait (code 1). It lasts `PWRT_TICKS` RC clock periods, plus synchronizer delay.
- R3: With `cfg_pwrt_n` = 1, the power-up wait never appears.
- R4: In mode codes 3, 4, 5 and 6 (LP, XT, HS, PLL crystal), the oscillator wait (code 2) follows the power-up wait or idle. It lasts `OST_CYCLES` oscillator cycles, plus one cycle.
- R5: In mode 6 only, the PLL wait (code 3) follows the oscillator wait. It lasts `PLL_TICKS` RC periods, plus synchronizer delay.
- R6: In mode codes 0, 1 and 2 (RC, external clock, internal), no oscillator wait occurs. With the power-up wait also disabled, `core_hold` falls within 4 oscillator cycles of `por` falling.
- R7: While `mclr_n` is low, `core_hold` stays 1 and the waits still progress to the run stage. Once in the run stage, `core_hold` falls within 4 oscillator cycles of `mclr_n` rising.
- R8: A `pm_wake` pulse in the run stage in modes 3 to 6 enters the oscillator wait without a power-up wait. In mode 6 it also enters the PLL wait afterwards. In modes 0 to 2 the pulse has no effect.
- R9: A `por` pulse during any wait aborts the sequence. A full-length power-up wait and a full-length oscillator wait then follow again.
- R10: `core_hold` is 0 only in the run stage (code 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Main oscillator clock; the sequencer and release run here |
| rc_clk | input | 1 | Slow internal RC clock for the power-up and PLL waits |
| por | input | 1 | Power-on pulse, active high, synchronous reset of both domains |
| mclr_n | input | 1 | External master clear, active low, asynchronous |
| pm_wake | input | 1 | One-cycle pulse on osc_clk: exit from a power-managed mode |
| cfg_osc_mode | input | 3 | Oscillator mode code 0..6 |
| cfg_pwrt_n | input | 1 | 0 enables the power-up wait |
| core_hold | output | 1 | 1 keeps the core in reset |
| stage_o | output | 3 | Current stage: 0 idle, 1 power-up, 2 oscillator, 3 PLL, 4 run |

## Verification
The sequence is started with each class of oscillator mode: crystal, PLL crystal, and RC/external clock. It is started both with and without the power-up wait. The measured length and order of the stages show whether each wait was included or skipped for that combination. Holding master clear through a complete sequence shows that the waits do not depend on it. A wake pulse is given in a crystal mode and in an RC mode, which shows that the power-up wait is left out on wake and that a wake is ignored where no settling is needed. A power-on pulse in the middle of the oscillator wait shows that the counters are cleared and not resumed.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [2:0] {
        OSC_RC    = 3'd0,
        OSC_EC    = 3'd1,
        OSC_INT   = 3'd2,
        OSC_LP    = 3'd3,
        OSC_XT    = 3'd4,
        OSC_HS    = 3'd5,
        OSC_HSPLL = 3'd6
    } osc_mode_e;

    typedef enum logic [2:0] {
        STG_IDLE  = 3'd0,
        STG_PWRUP = 3'd1,
        STG_OSCW  = 3'd2,
        STG_PLLW  = 3'd3,
        STG_RUN   = 3'd4
    } stage_e;

    typedef struct packed {
        logic pll;
        logic ost;
        logic pwrt;
    } run_req_t;

    function automatic logic mode_needs_ost(input logic [2:0] m);
        return (m == OSC_LP) || (m == OSC_XT) || (m == OSC_HS) || (m == OSC_HSPLL);
    endfunction

    function automatic logic mode_needs_pll(input logic [2:0] m);
        return (m == OSC_HSPLL);
    endfunction

    function automatic stage_e stage_after_pwrup(input logic [2:0] m);
        return mode_needs_ost(m) ? STG_OSCW : STG_RUN;
    endfunction

    function automatic stage_e stage_after_idle(input logic pwrt_n, input logic [2:0] m);
        return (!pwrt_n) ? STG_PWRUP : stage_after_pwrup(m);
    endfunction

endpackage

// File: rtl/por_seq_sync.sv
module por_seq_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic ff1, ff2;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff1 <= RST_VAL;
            ff2 <= RST_VAL;
        end else begin
            ff1 <= d;
            ff2 <= ff1;
        end
    end

    assign q = ff2;
endmodule

// File: rtl/por_seq_timer.sv
module por_seq_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (cnt == LAST) begin
            done <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
    import por_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_pwrt_n,
    input  logic       wake,
    input  logic       pwrt_done,
    input  logic       ost_done,
    input  logic       pll_done,
    input  logic       mclr_ok,
    output stage_e     stage,
    output run_req_t   run,
    output logic       core_hold
);
    stage_e nxt;

    always_comb begin
        nxt = stage;
        unique case (stage)
            STG_IDLE:  nxt = stage_after_idle(cfg_pwrt_n, cfg_mode);
            STG_PWRUP: if (pwrt_done) nxt = stage_after_pwrup(cfg_mode);
            STG_OSCW:  if (ost_done)  nxt = mode_needs_pll(cfg_mode) ? STG_PLLW : STG_RUN;
            STG_PLLW:  if (pll_done)  nxt = STG_RUN;
            STG_RUN:   if (wake && mode_needs_ost(cfg_mode)) nxt = STG_OSCW;
            default:   nxt = STG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= STG_IDLE;
            run       <= '0;
            core_hold <= 1'b1;
        end else begin
            stage     <= nxt;
            run.pwrt  <= (nxt == STG_PWRUP);
            run.ost   <= (nxt == STG_OSCW);
            run.pll   <= (nxt == STG_PLLW);
            core_hold <= !((nxt == STG_RUN) && mclr_ok);
        end
    end
endmodule

// File: rtl/por_seq_top.sv
module por_seq_top
    import por_seq_pkg::*;
#(
    parameter int unsigned PWRT_TICKS = 2048,
    parameter int unsigned OST_CYCLES = 1024,
    parameter int unsigned PLL_TICKS  = 64
) (
    input  logic       osc_clk,
    input  logic       rc_clk,
    input  logic       por,
    input  logic       mclr_n,
    input  logic       pm_wake,
    input  logic [2:0] cfg_osc_mode,
    input  logic       cfg_pwrt_n,
    output logic       core_hold,
    output logic [2:0] stage_o
);
    localparam int unsigned N_RC = 2;
    localparam int unsigned RC_TICKS [N_RC] = '{PWRT_TICKS, PLL_TICKS};

    stage_e      stage;
    run_req_t    run;
    logic        mclr_ok;
    logic        ost_done;
    logic [N_RC-1:0] rc_run;
    logic [N_RC-1:0] rc_done;

    assign rc_run = {run.pll, run.pwrt};

    por_seq_sync #(.RST_VAL(1'b0)) u_mclr_sync (
        .clk(osc_clk), .rst(por), .d(mclr_n), .q(mclr_ok)
    );

    for (genvar g = 0; g < N_RC; g++) begin : g_rc
        logic run_rc;
        logic done_rc;

        por_seq_sync #(.RST_VAL(1'b0)) u_run_in (
            .clk(rc_clk), .rst(por), .d(rc_run[g]), .q(run_rc)
        );
        por_seq_timer #(.TICKS(RC_TICKS[g])) u_tmr (
            .clk(rc_clk), .rst(por), .run(run_rc), .done(done_rc)
        );
        por_seq_sync #(.RST_VAL(1'b0)) u_done_out (
            .clk(osc_clk), .rst(por), .d(done_rc), .q(rc_done[g])
        );
    end

    por_seq_timer #(.TICKS(OST_CYCLES)) u_ost (
        .clk(osc_clk), .rst(por), .run(run.ost), .done(ost_done)
    );

    por_seq_fsm u_fsm (
        .clk       (osc_clk),
        .rst       (por),
        .cfg_mode  (cfg_osc_mode),
        .cfg_pwrt_n(cfg_pwrt_n),
        .wake      (pm_wake),
        .pwrt_done (rc_done[0]),
        .ost_done  (ost_done),
        .pll_done  (rc_done[1]),
        .mclr_ok   (mclr_ok),
        .stage     (stage),
        .run       (run),
        .core_hold (core_hold)
    );

    assign stage_o = stage;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk
    import por_seq_pkg::*;
(
    input logic       osc_clk,
    input logic       por,
    input logic       mclr_n,
    input logic [2:0] cfg_osc_mode,
    input logic       cfg_pwrt_n,
    input logic       core_hold,
    input logic [2:0] stage_o
);
    assert_idle_in_por_R1: assert property (@(posedge osc_clk)
        por |=> (stage_o == STG_IDLE) && core_hold);

    assert_pwrup_from_idle_R2: assert property (@(posedge osc_clk) disable iff (por)
        (stage_o == STG_PWRUP && $past(stage_o) != STG_PWRUP) |-> $past(stage_o) == STG_IDLE);

    assert_no_pwrup_when_off_R3: assert property (@(posedge osc_clk) disable iff (por)
        (stage_o == STG_PWRUP) |-> !cfg_pwrt_n);

    assert_ost_only_crystal_R4: assert property (@(posedge osc_clk) disable iff (por)
        (stage_o == STG_OSCW) |-> mode_needs_ost(cfg_osc_mode));

    assert_pll_after_ost_R5: assert property (@(posedge osc_clk) disable iff (por)
        (stage_o == STG_PLLW && $past(stage_o) != STG_PLLW) |->
            ($past(stage_o) == STG_OSCW) && mode_needs_pll(cfg_osc_mode));

    assert_mclr_holds_R7: assert property (@(posedge osc_clk) disable iff (por)
        !$past(mclr_n, 3) |-> core_hold);

    assert_release_in_run_R10: assert property (@(posedge osc_clk) disable iff (por)
        !core_hold |-> stage_o == STG_RUN);
endmodule

bind por_seq_top por_seq_chk u_chk (
    .osc_clk     (osc_clk),
    .por         (por),
    .mclr_n      (mclr_n),
    .cfg_osc_mode(cfg_osc_mode),
    .cfg_pwrt_n  (cfg_pwrt_n),
    .core_hold   (core_hold),
    .stage_o     (stage_o)
);

// File: tb/tb_por_seq_top.sv
`timescale 1ns/1ps
module tb_por_seq_top;
    import por_seq_pkg::*;

    localparam int PWRT_T = 2048;
    localparam int OST_T  = 1024;
    localparam int PLL_T  = 64;
    localparam int RATIO  = 4;   // rc period / osc period

    logic       osc_clk = 1'b0;
    logic       rc_clk  = 1'b0;
    logic       por     = 1'b1;
    logic       mclr_n  = 1'b1;
    logic       pm_wake = 1'b0;
    logic [2:0] cfg_osc_mode = OSC_HS;
    logic       cfg_pwrt_n   = 1'b0;
    logic       core_hold;
    logic [2:0] stage_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    por_seq_top #(.PWRT_TICKS(PWRT_T), .OST_CYCLES(OST_T), .PLL_TICKS(PLL_T)) dut (
        .osc_clk(osc_clk), .rc_clk(rc_clk), .por(por), .mclr_n(mclr_n),
        .pm_wake(pm_wake), .cfg_osc_mode(cfg_osc_mode), .cfg_pwrt_n(cfg_pwrt_n),
        .core_hold(core_hold), .stage_o(stage_o)
    );

    always #5 osc_clk = ~osc_clk;
    initial begin
        #2;
        forever #20 rc_clk = ~rc_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what,
                             input int act, input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic start_por(input logic [2:0] mode, input logic pwrt_n);
        @(negedge osc_clk);
        cfg_osc_mode = mode;
        cfg_pwrt_n   = pwrt_n;
        por = 1'b1;
        repeat (20) @(negedge osc_clk);
        check(stage_o == STG_IDLE, "R1", "stage during por", int'(stage_o), 0);
        check(core_hold == 1'b1, "R1", "hold during por", int'(core_hold), 1);
        por = 1'b0;
    endtask

    // waits for stage st, counts its length, reports the following stage
    task automatic time_stage(input logic [2:0] st, input int lo, input int hi,
                              input string req, output logic [2:0] after);
        int n = 0;
        int w = 0;
        while (stage_o != st && w < 20000) begin
            @(negedge osc_clk);
            w++;
        end
        while (stage_o == st && n < 20000) begin
            @(negedge osc_clk);
            n++;
        end
        check_rng(req, $sformatf("length of stage %0d", st), n, lo, hi);
        after = stage_o;
    endtask

    localparam int PW_LO = PWRT_T * RATIO - 2, PW_HI = PWRT_T * RATIO + 40;
    localparam int OS_LO = OST_T, OS_HI = OST_T + 4;
    localparam int PL_LO = PLL_T * RATIO - 2, PL_HI = PLL_T * RATIO + 40;

    task automatic t_hs_full();
        logic [2:0] nx;
        start_por(OSC_HS, 1'b0);
        @(negedge osc_clk);
        check(stage_o == STG_PWRUP, "R2", "first stage HS", int'(stage_o), 1);
        time_stage(STG_PWRUP, PW_LO, PW_HI, "R2", nx);
        check(nx == STG_OSCW, "R4", "after power-up HS", int'(nx), 2);
        check(core_hold == 1'b1, "R10", "hold in osc wait", int'(core_hold), 1);
        time_stage(STG_OSCW, OS_LO, OS_HI, "R4", nx);
        check(nx == STG_RUN, "R4", "after osc wait HS", int'(nx), 4);
        @(negedge osc_clk);
        check(core_hold == 1'b0, "R10", "hold in run", int'(core_hold), 0);
    endtask

    task automatic t_hspll_full();
        logic [2:0] nx;
        start_por(OSC_HSPLL, 1'b0);
        time_stage(STG_PWRUP, PW_LO, PW_HI, "R2", nx);
        time_stage(STG_OSCW, OS_LO, OS_HI, "R4", nx);
        check(nx == STG_PLLW, "R5", "after osc wait PLL", int'(nx), 3);
        time_stage(STG_PLLW, PL_LO, PL_HI, "R5", nx);
        check(nx == STG_RUN, "R5", "after PLL wait", int'(nx), 4);
    endtask

    task automatic t_wake_pll();
        logic [2:0] nx;
        @(negedge osc_clk);
        pm_wake = 1'b1;
        @(negedge osc_clk);
        pm_wake = 1'b0;
        check(stage_o == STG_OSCW, "R8", "stage after wake", int'(stage_o), 2);
        check(core_hold == 1'b1, "R8", "hold after wake", int'(core_hold), 1);
        time_stage(STG_OSCW, OS_LO, OS_HI, "R8", nx);
        check(nx == STG_PLLW, "R8", "PLL wait after wake", int'(nx), 3);
        time_stage(STG_PLLW, PL_LO, PL_HI, "R8", nx);
        check(nx == STG_RUN, "R8", "run after wake", int'(nx), 4);
    endtask

    task automatic t_rc_pwrt();
        logic [2:0] nx;
        start_por(OSC_RC, 1'b0);
        time_stage(STG_PWRUP, PW_LO, PW_HI, "R2", nx);
        check(nx == STG_RUN, "R6", "RC mode skips osc wait", int'(nx), 4);
    endtask

    task automatic t_wake_rc();
        bit ok = 1'b1;
        @(negedge osc_clk);
        pm_wake = 1'b1;
        @(negedge osc_clk);
        pm_wake = 1'b0;
        repeat (50) begin
            if (stage_o != STG_RUN || core_hold != 1'b0) ok = 1'b0;
            @(negedge osc_clk);
        end
        check(ok, "R8", "wake ignored in RC mode", int'(stage_o), 4);
    endtask

    task automatic t_ec_none();
        start_por(OSC_EC, 1'b1);
        repeat (4) @(negedge osc_clk);
        check(stage_o == STG_RUN, "R6", "EC no-wait stage", int'(stage_o), 4);
        check(core_hold == 1'b0, "R6", "EC no-wait release", int'(core_hold), 0);
    endtask

    task automatic t_xt_nopwrt();
        logic [2:0] nx;
        start_por(OSC_XT, 1'b1);
        @(negedge osc_clk);
        check(stage_o == STG_OSCW, "R3", "XT first stage without power-up", int'(stage_o), 2);
        time_stage(STG_OSCW, OS_LO - 1, OS_HI, "R4", nx);
        check(nx == STG_RUN, "R4", "XT after osc wait", int'(nx), 4);
    endtask

    task automatic t_mclr_long();
        int w = 0;
        @(negedge osc_clk);
        mclr_n = 1'b0;
        start_por(OSC_HS, 1'b0);
        while (stage_o != STG_RUN && w < 20000) begin
            @(negedge osc_clk);
            w++;
        end
        repeat (10) @(negedge osc_clk);
        check(stage_o == STG_RUN, "R7", "waits finish under mclr", int'(stage_o), 4);
        check(core_hold == 1'b1, "R7", "hold under mclr", int'(core_hold), 1);
        mclr_n = 1'b1;
        repeat (4) @(negedge osc_clk);
        check(core_hold == 1'b0, "R7", "quick release on mclr", int'(core_hold), 0);
    endtask

    task automatic t_abort();
        logic [2:0] nx;
        int w = 0;
        start_por(OSC_HS, 1'b0);
        while (stage_o != STG_OSCW && w < 20000) begin
            @(negedge osc_clk);
            w++;
        end
        repeat (300) @(negedge osc_clk);
        start_por(OSC_HS, 1'b0);
        time_stage(STG_PWRUP, PW_LO, PW_HI, "R9", nx);
        time_stage(STG_OSCW, OS_LO, OS_HI, "R9", nx);
        check(nx == STG_RUN, "R9", "run after restart", int'(nx), 4);
    endtask

    initial begin
        t_hs_full();
        t_hspll_full();
        t_wake_pll();
        t_rc_pwrt();
        t_wake_rc();
        t_ec_none();
        t_xt_nopwrt();
        t_mclr_long();
        t_abort();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge osc_clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (sequence hung): actual stage %0d expected completion", stage_o);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule